// File: doc/BRIEF.md
# Motion-Adaptive Line-Doubling Deinterlacer

The block turns an interlaced luma stream into a progressive one. For every received line it emits two lines at the full clock rate: the received line itself and a synthesised line for the missing raster position next to it. The output therefore has twice the line rate and twice the lines per field of the input. Input samples arrive on a clock enable at half the system clock rate, so one received line and one output line pair take the same time.

For each pixel of a synthesised line the block makes its own motion decision. It compares the current pixel with the pixel at the same place one frame earlier, using a programmable threshold. In still areas it copies the co-sited pixel of the previous field, which an external field memory supplies next to the live stream. In moving areas it averages the received lines directly above and below, using an internal line store. On the first line of a field no line exists above, so the synthesised line repeats the received line.

The pair for received line N is emitted while line N+1 is being received. A field-parity input, sampled at each field start, sets whether the synthesised line comes before or after the received line in each pair.

Top module: `ldd_top`

## Requirements
- R1: After reset `pix_vld_o` and `line_o` are low. No output pixel appears until a received line has been completely stored, which means before the second accepted line start.
- R2: Each received line yields exactly two output lines of `LINE_LEN` pixels, one pixel per clock. `line_o` is high on the first pixel of each output line and only while `pix_vld_o` is high. The pair for line N starts after the line start of line N+1.
- R3: The received-line half of a pair reproduces the stored input samples unchanged and in order.
- R4: A pixel is still when |`pix_i` − `fref_i`| ≤ `thresh_i`; equality counts as still. A still pixel of a synthesised line equals `prev_i` at the same column.
- R5: A moving pixel of a synthesised line equals (above + below + 1) >> 1. The sum is formed at 9 bits, so 255 and 255 give 255 and 255 and 254 give 255. Above is the same column of the previous received line and below is the current one.
- R6: On the first line of a field (`field_start_i` high with its line start), every synthesised pixel equals the received pixel below it, whatever the motion decision.
- R7: `parity_i` is sampled only at a field start and holds for every line of that field. Value 0 puts the synthesised line first in each pair, and value 1 puts the received line first. `parity_i` has no effect on lines that do not start a field.
- R8: Samples beyond `LINE_LEN` in one received line are ignored. They change neither that line's pair nor the next line's averages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, twice the input sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_vld_i | input | 1 | Input sample enable |
| line_start_i | input | 1 | First sample of a received line (qualified by `pix_vld_i`) |
| field_start_i | input | 1 | Line start that begins a field |
| parity_i | input | 1 | Pair order for the field, sampled at field start |
| pix_i | input | 8 | Current-field luma sample |
| prev_i | input | 8 | Previous-field sample at the missing line's position |
| fref_i | input | 8 | Sample one frame earlier, used for the motion test |
| thresh_i | input | 8 | Motion threshold |
| pix_o | output | 8 | Progressive luma sample |
| pix_vld_o | output | 1 | Output sample valid |
| line_o | output | 1 | First pixel of an output line |

## Verification
The bench aims at the threshold edge. It sets the frame difference to exactly the threshold and to the threshold plus one. A design that treats equality as motion, or that compares the wrong operands, would blend pixels that should have been copied. Lines of 254 and 255 driven with a zero threshold expose an average formed at 8 bits, which wraps to a small value. A field start with random parity on the later lines, and a line with surplus samples, catch a pair order that follows the live `parity_i` and a line store that lets extra samples overwrite columns or wrap them into the next line's averages.

// File: rtl/ldd_pkg.sv
package ldd_pkg;
  // order of the two lines in an output pair
  typedef enum logic {
    ORD_INTP_FIRST = 1'b0,
    ORD_ORIG_FIRST = 1'b1
  } pair_ord_e;
endpackage

// File: rtl/ldd_motion_det.sv
module ldd_motion_det #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] cur_i,
  input  logic [PIX_W-1:0] ref_i,
  input  logic [PIX_W-1:0] thr_i,
  output logic             mov_o
);
  logic [PIX_W-1:0] diff;

  always_comb begin
    diff  = (cur_i > ref_i) ? (cur_i - ref_i) : (ref_i - cur_i);
    mov_o = diff > thr_i;   // equal counts as still
  end
endmodule

// File: rtl/ldd_interp.sv
module ldd_interp #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] above_i,
  input  logic [PIX_W-1:0] below_i,
  input  logic [PIX_W-1:0] prev_i,
  input  logic             mov_i,
  input  logic             first_i,
  output logic [PIX_W-1:0] px_o
);
  localparam int SW = PIX_W + 1;
  logic [SW-1:0] sum;
  logic [PIX_W-1:0] avg;

  always_comb begin
    sum = {1'b0, above_i} + {1'b0, below_i} + SW'(1);
    avg = sum[SW-1:1];
    if (first_i)    px_o = below_i;
    else if (mov_i) px_o = avg;
    else            px_o = prev_i;
  end
endmodule

// File: rtl/ldd_line_bank.sv
module ldd_line_bank #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 910,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [PIX_W-1:0] orig_wd_i,
  input  logic [PIX_W-1:0] intp_wd_i,
  input  logic [AW-1:0]    aaddr_i,
  output logic [PIX_W-1:0] a_orig_o,
  input  logic [AW-1:0]    baddr_i,
  output logic [PIX_W-1:0] b_orig_o,
  output logic [PIX_W-1:0] b_intp_o
);
  logic [PIX_W-1:0] orig_mem [DEPTH];
  logic [PIX_W-1:0] intp_mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      orig_mem[waddr_i] <= orig_wd_i;
      intp_mem[waddr_i] <= intp_wd_i;
    end
  end

  assign a_orig_o = orig_mem[aaddr_i];
  assign b_orig_o = orig_mem[baddr_i];
  assign b_intp_o = intp_mem[baddr_i];
endmodule

// File: rtl/ldd_out_seq.sv
module ldd_out_seq
  import ldd_pkg::*;
#(
  parameter int DEPTH = 910,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  pair_ord_e     ord_i,
  output logic          run_o,
  output logic [AW-1:0] col_o,
  output logic          sel_intp_o,
  output logic          sol_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic      half_q;
  pair_ord_e ord_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      col_o  <= '0;
      half_q <= 1'b0;
      ord_q  <= ORD_INTP_FIRST;
    end else if (start_i) begin
      run_o  <= 1'b1;
      col_o  <= '0;
      half_q <= 1'b0;
      ord_q  <= ord_i;
    end else if (run_o) begin
      if (col_o == LAST) begin
        col_o <= '0;
        if (half_q) run_o  <= 1'b0;
        else        half_q <= 1'b1;
      end else begin
        col_o <= col_o + AW'(1);
      end
    end
  end

  assign sel_intp_o = (ord_q == ORD_INTP_FIRST) ? ~half_q : half_q;
  assign sol_o      = run_o && (col_o == '0);
endmodule

// File: rtl/ldd_top.sv
module ldd_top
  import ldd_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 910
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_vld_i,
  input  logic             line_start_i,
  input  logic             field_start_i,
  input  logic             parity_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] prev_i,
  input  logic [PIX_W-1:0] fref_i,
  input  logic [PIX_W-1:0] thresh_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             pix_vld_o,
  output logic             line_o
);
  localparam int AW = $clog2(LINE_LEN);
  localparam int CW = $clog2(LINE_LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(LINE_LEN);

  logic          wb_q, ob_q, first_q, fpar_q, lpar_q, have_q;
  logic [CW-1:0] wcol_q;

  logic          sol, wb_eff, first_eff, lpar_eff, wr_en, mov;
  logic [CW-1:0] wcol_eff;
  logic [AW-1:0] waddr;
  logic [PIX_W-1:0] above_px, intp_px;

  logic [PIX_W-1:0] a_orig [2];
  logic [PIX_W-1:0] b_orig [2];
  logic [PIX_W-1:0] b_intp [2];

  logic          run, sel_intp, seq_sol;
  logic [AW-1:0] rcol;

  // write side: a line start switches bank in the same cycle
  always_comb begin
    sol       = pix_vld_i && line_start_i;
    wb_eff    = sol ? ~wb_q : wb_q;
    wcol_eff  = sol ? '0 : wcol_q;
    first_eff = sol ? field_start_i : first_q;
    lpar_eff  = sol ? (field_start_i ? parity_i : fpar_q) : lpar_q;
    wr_en     = pix_vld_i && (wcol_eff < LEN_C);
    waddr     = wcol_eff[AW-1:0];
    above_px  = a_orig[~wb_eff];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_q    <= 1'b0;
      ob_q    <= 1'b0;
      first_q <= 1'b0;
      fpar_q  <= 1'b0;
      lpar_q  <= 1'b0;
      have_q  <= 1'b0;
      wcol_q  <= LEN_C;
    end else if (sol) begin
      wb_q    <= ~wb_q;
      ob_q    <= wb_q;
      first_q <= field_start_i;
      lpar_q  <= lpar_eff;
      have_q  <= 1'b1;
      wcol_q  <= CW'(1);
      if (field_start_i) fpar_q <= parity_i;
    end else if (wr_en) begin
      wcol_q <= wcol_q + CW'(1);
    end
  end

  ldd_motion_det #(.PIX_W(PIX_W)) u_mdet (
    .cur_i (pix_i),
    .ref_i (fref_i),
    .thr_i (thresh_i),
    .mov_o (mov)
  );

  ldd_interp #(.PIX_W(PIX_W)) u_intp (
    .above_i (above_px),
    .below_i (pix_i),
    .prev_i  (prev_i),
    .mov_i   (mov),
    .first_i (first_eff),
    .px_o    (intp_px)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ldd_line_bank #(.PIX_W(PIX_W), .DEPTH(LINE_LEN)) u_bank (
      .clk_i     (clk_i),
      .we_i      (wr_en && (wb_eff == 1'(b))),
      .waddr_i   (waddr),
      .orig_wd_i (pix_i),
      .intp_wd_i (intp_px),
      .aaddr_i   (waddr),
      .a_orig_o  (a_orig[b]),
      .baddr_i   (rcol),
      .b_orig_o  (b_orig[b]),
      .b_intp_o  (b_intp[b])
    );
  end

  ldd_out_seq #(.DEPTH(LINE_LEN)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (sol && have_q),
    .ord_i      (pair_ord_e'(lpar_q)),
    .run_o      (run),
    .col_o      (rcol),
    .sel_intp_o (sel_intp),
    .sol_o      (seq_sol)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o     <= '0;
      pix_vld_o <= 1'b0;
      line_o    <= 1'b0;
    end else begin
      pix_vld_o <= run;
      line_o    <= seq_sol;
      pix_o     <= sel_intp ? b_intp[ob_q] : b_orig[ob_q];
    end
  end
endmodule

// File: rtl/ldd_chk.sv
module ldd_chk #(
  parameter int PIX_W    = 8,
  parameter int LINE_LEN = 910
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_vld_i,
  input logic             line_start_i,
  input logic             pix_vld_o,
  input logic             line_o,
  input logic             wr_en,
  input logic             first_eff,
  input logic             mov,
  input logic [PIX_W-1:0] above_px,
  input logic [PIX_W-1:0] pix_i,
  input logic [PIX_W-1:0] intp_px
);
  localparam int RW = $clog2(LINE_LEN + 1) + 1;

  logic [1:0]       sol_cnt;
  logic [RW-1:0]    run_cnt;
  logic [PIX_W-1:0] lo, hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sol_cnt <= '0;
      run_cnt <= '0;
    end else begin
      if (pix_vld_i && line_start_i && sol_cnt != 2'd2) sol_cnt <= sol_cnt + 2'd1;
      if (pix_vld_o) run_cnt <= line_o ? RW'(1) : run_cnt + RW'(1);
    end
  end

  always_comb begin
    lo = (above_px < pix_i) ? above_px : pix_i;
    hi = (above_px < pix_i) ? pix_i : above_px;
  end

  a_r1_quiet_until_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sol_cnt < 2'd2) |-> !pix_vld_o);

  a_r2_strobe_in_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o |-> pix_vld_o);

  a_r2_line_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_vld_o && !line_o) |-> (run_cnt != '0 && run_cnt < RW'(LINE_LEN)));

  a_r5_avg_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !first_eff && mov) |-> (intp_px >= lo && intp_px <= hi));

  a_r6_first_repeats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && first_eff) |-> (intp_px == pix_i));
endmodule

bind ldd_top ldd_chk #(.PIX_W(PIX_W), .LINE_LEN(LINE_LEN)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pix_vld_i    (pix_vld_i),
  .line_start_i (line_start_i),
  .pix_vld_o    (pix_vld_o),
  .line_o       (line_o),
  .wr_en        (wr_en),
  .first_eff    (first_eff),
  .mov          (mov),
  .above_px     (above_px),
  .pix_i        (pix_i),
  .intp_px      (intp_px)
);

// File: tb/ldd_top_tb_top.sv
module ldd_top_tb_top;
  localparam int LEN = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pix_vld_i = 1'b0, line_start_i = 1'b0, field_start_i = 1'b0, parity_i = 1'b0;
  logic [7:0] pix_i = '0, prev_i = '0, fref_i = '0, thresh_i = '0;
  logic [7:0] pix_o;
  logic       pix_vld_o, line_o;

  int checks = 0, errors = 0, outs = 0;
  bit done = 0;

  logic [7:0] exp_q [$];
  bit         exp_sol [$];
  string      exp_tag [$];

  logic [7:0] above_m [LEN];
  logic [7:0] orig_m  [LEN];
  logic [7:0] intp_m  [LEN];
  string      tag_m   [LEN];
  bit         fpar_m = 0;

  always #5 clk = ~clk;

  ldd_top #(.PIX_W(8), .LINE_LEN(LEN)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pix_vld_i(pix_vld_i), .line_start_i(line_start_i),
    .field_start_i(field_start_i), .parity_i(parity_i), .pix_i(pix_i), .prev_i(prev_i),
    .fref_i(fref_i), .thresh_i(thresh_i), .pix_o(pix_o), .pix_vld_o(pix_vld_o), .line_o(line_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (pix_vld_o) begin
        outs++;
        if (exp_q.size() == 0) check(1'b0, "R1", pix_o, -1);
        else begin
          logic [7:0] e; bit s; string t;
          e = exp_q.pop_front(); s = exp_sol.pop_front(); t = exp_tag.pop_front();
          check(pix_o == e, t, pix_o, e);
          check(line_o == s, "R2", line_o, s);
        end
      end else if (line_o) begin
        check(1'b0, "R2", line_o, 0);
      end
    end
  end

  // mode 0 random, 1 saturated motion, 2 threshold edge
  task automatic send_line(input bit fs, input bit par, input int mode, input int npix,
                           input logic [7:0] thr);
    logic [7:0] px, pv, fr;
    int d;
    bit mv;
    if (fs) fpar_m = par;
    for (int c = 0; c < npix; c++) begin
      px = 8'($urandom); pv = 8'($urandom); fr = 8'($urandom);
      if (mode == 1) begin
        px = (c % 2 == 1) ? 8'd255 : 8'd254;
        fr = 8'd0;
      end else if (mode == 2) begin
        if (int'(px) + int'(thr) + 1 <= 255) fr = (c % 2 == 1) ? px + thr : px + thr + 8'd1;
        else fr = (c % 2 == 1) ? px - thr : px - thr - 8'd1;
      end
      d  = (px > fr) ? int'(px) - int'(fr) : int'(fr) - int'(px);
      mv = d > int'(thr);
      if (c < LEN) begin
        orig_m[c] = px;
        if (fs) begin intp_m[c] = px; tag_m[c] = "R6"; end
        else if (mv) begin
          intp_m[c] = 8'((int'(above_m[c]) + int'(px) + 1) >> 1); tag_m[c] = "R5";
        end else begin
          intp_m[c] = pv; tag_m[c] = "R4";
        end
      end
      @(negedge clk);
      pix_vld_i = 1'b1; line_start_i = (c == 0); field_start_i = fs && (c == 0);
      parity_i = fs ? par : 1'($urandom);   // R7: ignored off field start
      pix_i = px; prev_i = pv; fref_i = fr; thresh_i = thr;
      @(negedge clk);
      pix_vld_i = 1'b0; line_start_i = 1'b0; field_start_i = 1'b0;
    end
    for (int h = 0; h < 2; h++) begin
      bit intp_half;
      intp_half = (fpar_m == 1'b0) ? (h == 0) : (h == 1);
      for (int c = 0; c < LEN; c++) begin
        exp_q.push_back(intp_half ? intp_m[c] : orig_m[c]);
        exp_sol.push_back(c == 0);
        exp_tag.push_back(intp_half ? (npix > LEN ? "R8" : (h == 0 && fpar_m == 1'b0 ? "R7" : tag_m[c]))
                                    : (npix > LEN ? "R8" : "R3"));
      end
    end
    for (int c = 0; c < LEN; c++) above_m[c] = orig_m[c];
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(pix_vld_o == 1'b0, "R1", pix_vld_o, 0);
    check(line_o == 1'b0, "R1", line_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(pix_vld_o == 1'b0, "R1", pix_vld_o, 0);

    send_line(1, 0, 0, LEN, 8'd20);
    check(outs == 0, "R1", outs, 0);
    for (int i = 0; i < 6; i++) send_line(0, 0, 0, LEN, 8'($urandom));
    send_line(0, 0, 2, LEN, 8'd10);
    send_line(0, 0, 2, LEN, 8'd0);
    send_line(0, 0, 1, LEN, 8'd0);
    send_line(0, 0, 1, LEN, 8'd0);

    send_line(1, 1, 1, LEN, 8'd0);
    for (int i = 0; i < 5; i++) send_line(0, 0, 0, LEN, 8'($urandom));
    send_line(0, 0, 0, LEN + 3, 8'd40);
    send_line(0, 0, 0, LEN, 8'd40);
    send_line(0, 0, 2, LEN, 8'd254);

    send_line(1, 0, 0, LEN, 8'd255);
    send_line(0, 0, 0, LEN, 8'd255);
    send_line(0, 0, 0, LEN, 8'd0);
    for (int i = 0; i < 10; i++) send_line(0, 0, (i % 3 == 2) ? 2 : 0, LEN, 8'($urandom));

    send_line(1, 1, 0, LEN, 8'd30);
    repeat (4 * LEN) @(negedge clk);
    // last line's pair stays pending: no line start follows it
    check(exp_q.size() == 2 * LEN, "R2", exp_q.size(), 2 * LEN);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule